// File: doc/BRIEF.md
# Outstanding-Request Latency Accumulator

This block measures the average latency of requests crossing a link without storing a timestamp per request. For each traffic channel it keeps a count of requests now in flight. Every cycle that count is added into a cumulative-occupancy counter. A request counter and a shared cycle counter sit beside it. Software reads the counters and divides cumulative occupancy by the request count to get the mean latency in cycles. A request issued on one clock edge and retired L edges later adds exactly L to the cumulative counter.

The block has `NCH` independent channels, each fed by an issue strobe and a return strobe. With the default four channels, channel 0 carries incoming reads, channel 1 incoming writes, channel 2 outgoing reads and channel 3 outgoing writes. Every strobe also carries the index of the accelerator it belongs to. A selection mask limits counting to chosen accelerators. A peer-processor mode switches off the write channels. An enable and a synchronous clear act on all counters together.

Top module: `lat_accum_monitor`

## Requirements
- R1: On each clock edge with `cnt_en` high, a channel's request counter rises by one if that channel has a qualified issue strobe.
- R2: On each clock edge with `cnt_en` high, a channel's cumulative counter adds that channel's in-flight count as it stood before the edge. A request issued on one edge and returned L edges later therefore contributes L.
- R3: The cycle counter rises by one on every clock edge with `cnt_en` high.
- R4: The in-flight count goes up on a qualified issue and down on a qualified return. When both occur on the same edge it stays unchanged. It holds at its maximum of 2^OCC_W-1.
- R5: A qualified return with zero in flight and no issue on the same edge leaves the in-flight count at zero and sets that channel's `underflow_err` bit. The bit stays set until reset or `cnt_clr`.
- R6: A strobe is qualified only if `acc_mask` is all zeros or bit `acc_mask[idx]` is set, where idx is the strobe's accelerator index. A masked-out strobe changes no counter and no in-flight count.
- R7: While `peer_mode` is high, channels with an odd index (index bit 0 = 1, the write channels) ignore their strobes. Even-index (read) channels keep working.
- R8: The request, cumulative and cycle counters saturate at 2^CNT_W-1 and never wrap.
- R9: While `cnt_en` is low, the request, cumulative and cycle counters hold their values. The in-flight counts and error flags keep tracking.
- R10: When `cnt_clr` is high at a clock edge, the request, cumulative and cycle counters and the error flags become zero after that edge, whatever `cnt_en` is. The in-flight counts are kept.
- R11: After reset, every counter, in-flight count and error flag reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Enables the request, cumulative and cycle counters |
| cnt_clr | input | 1 | Synchronous clear of counters and error flags |
| peer_mode | input | 1 | High: link goes to a peer processor, so only even (read) channels count |
| acc_mask | input | NACC | Accelerator selection; all zeros selects every accelerator |
| iss_vld | input | NCH | Per-channel request issue strobe |
| iss_acc | input | NCH*ACC_W | Per-channel accelerator index of the issue |
| ret_vld | input | NCH | Per-channel response return strobe |
| ret_acc | input | NCH*ACC_W | Per-channel accelerator index of the return |
| req_cnt | output | NCH*CNT_W | Per-channel request counters |
| cum_cnt | output | NCH*CNT_W | Per-channel cumulative-occupancy counters |
| cyc_cnt | output | CNT_W | Elapsed enabled cycles |
| inflight | output | NCH*OCC_W | Per-channel in-flight count |
| underflow_err | output | NCH | Per-channel sticky underflow flag |

## Verification
The bench builds the block with four channels, four accelerators, and `CNT_W` and `OCC_W` both set to 8. With these narrow widths, a run of a few hundred cycles drives the in-flight count, the request counter, the cumulative counter and the cycle counter all into saturation. The R8 limits and the occupancy ceiling in R4 can therefore be observed directly, where 64-bit counters would never reach them. Four channels cover both the read channels and the write channels that peer mode disables.

// File: rtl/lam_pkg.sv
package lam_pkg;
  // Channel index bit 0 marks a write channel.
  function automatic logic ch_is_write(int ch);
    return ch[0];
  endfunction
endpackage

// File: rtl/lam_qual.sv
module lam_qual #(
  parameter int NACC  = 4,
  parameter int ACC_W = 2
) (
  input  logic             vld,
  input  logic [ACC_W-1:0] acc,
  input  logic [NACC-1:0]  mask,
  input  logic             active,
  output logic             hit
);
  function automatic logic acc_sel(logic [NACC-1:0] m, logic [ACC_W-1:0] a);
    if (m == '0) return 1'b1;
    if (int'(a) >= NACC) return 1'b0;
    return m[a];
  endfunction

  assign hit = vld && active && acc_sel(mask, acc);
endmodule

// File: rtl/lam_occ.sv
module lam_occ #(
  parameter int OCC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [OCC_W-1:0] occ,
  output logic             udf
);
  localparam logic [OCC_W-1:0] OCC_MAX = '1;

  logic [OCC_W-1:0] occ_nxt;

  function automatic logic [OCC_W-1:0] occ_step(logic [OCC_W-1:0] cur, logic up, logic dn);
    if (up && !dn) return (cur == OCC_MAX) ? cur : cur + 1'b1;
    if (dn && !up) return (cur == '0) ? cur : cur - 1'b1;
    return cur;
  endfunction

  assign occ_nxt = occ_step(occ, inc, dec);
  assign udf     = dec && !inc && (occ == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ_nxt;
  end
endmodule

// File: rtl/lam_sat_cnt.sv
module lam_sat_cnt #(
  parameter int W  = 64,
  parameter int AW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [AW-1:0] inc,
  output logic [W-1:0]  cnt
);
  function automatic logic [W-1:0] sat_add(logic [W-1:0] a, logic [AW-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {{(W+1-AW){1'b0}}, b};
    return s[W] ? '1 : s[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (en)       cnt <= sat_add(cnt, inc);
  end
endmodule

// File: rtl/lat_accum_monitor.sv
module lat_accum_monitor #(
  parameter int NCH   = 4,
  parameter int NACC  = 4,
  parameter int CNT_W = 64,
  parameter int OCC_W = 16,
  localparam int ACC_W = (NACC > 1) ? $clog2(NACC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cnt_en,
  input  logic                   cnt_clr,
  input  logic                   peer_mode,
  input  logic [NACC-1:0]        acc_mask,
  input  logic [NCH-1:0]         iss_vld,
  input  logic [NCH*ACC_W-1:0]   iss_acc,
  input  logic [NCH-1:0]         ret_vld,
  input  logic [NCH*ACC_W-1:0]   ret_acc,
  output logic [NCH*CNT_W-1:0]   req_cnt,
  output logic [NCH*CNT_W-1:0]   cum_cnt,
  output logic [CNT_W-1:0]       cyc_cnt,
  output logic [NCH*OCC_W-1:0]   inflight,
  output logic [NCH-1:0]         underflow_err
);
  // Qualified events and underflow pulses, named for the checker.
  logic [NCH-1:0] iss_q;
  logic [NCH-1:0] ret_q;
  logic [NCH-1:0] udf_evt;

  lam_sat_cnt #(.W(CNT_W), .AW(1)) u_cyc (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
    .inc(1'b1), .cnt(cyc_cnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic IS_WR = lam_pkg::ch_is_write(c);
    logic ch_act;
    logic err_q;

    assign ch_act = !(peer_mode && IS_WR);

    lam_qual #(.NACC(NACC), .ACC_W(ACC_W)) u_qi (
      .vld(iss_vld[c]), .acc(iss_acc[c*ACC_W +: ACC_W]), .mask(acc_mask),
      .active(ch_act), .hit(iss_q[c])
    );
    lam_qual #(.NACC(NACC), .ACC_W(ACC_W)) u_qr (
      .vld(ret_vld[c]), .acc(ret_acc[c*ACC_W +: ACC_W]), .mask(acc_mask),
      .active(ch_act), .hit(ret_q[c])
    );

    lam_occ #(.OCC_W(OCC_W)) u_occ (
      .clk(clk), .rst_n(rst_n), .inc(iss_q[c]), .dec(ret_q[c]),
      .occ(inflight[c*OCC_W +: OCC_W]), .udf(udf_evt[c])
    );

    lam_sat_cnt #(.W(CNT_W), .AW(1)) u_req (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
      .inc(iss_q[c]), .cnt(req_cnt[c*CNT_W +: CNT_W])
    );
    lam_sat_cnt #(.W(CNT_W), .AW(OCC_W)) u_cum (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
      .inc(inflight[c*OCC_W +: OCC_W]), .cnt(cum_cnt[c*CNT_W +: CNT_W])
    );

    always_ff @(posedge clk) begin
      if (!rst_n || cnt_clr) err_q <= 1'b0;
      else if (udf_evt[c])   err_q <= 1'b1;
    end
    assign underflow_err[c] = err_q;
  end
endmodule

// File: rtl/lam_chk.sv
module lam_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 64,
  parameter int OCC_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cnt_en,
  input logic                 cnt_clr,
  input logic [NCH-1:0]       iss_q,
  input logic [NCH-1:0]       ret_q,
  input logic [NCH-1:0]       udf_evt,
  input logic [NCH*OCC_W-1:0] occ,
  input logic [NCH-1:0]       err,
  input logic [NCH*CNT_W-1:0] req,
  input logic [CNT_W-1:0]     cyc
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R3
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_clr && cyc != CMAX) |=> cyc == $past(cyc) + 1'b1);
  // R9
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_clr) |=> $stable(cyc));
  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cyc == '0 && err == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R4
    same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_q[c] && ret_q[c]) |=> $stable(occ[c*OCC_W +: OCC_W]));
    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      udf_evt[c] |=> occ[c*OCC_W +: OCC_W] == '0);
    // R5
    udf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (udf_evt[c] && !cnt_clr) |=> err[c]);
    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err[c] && !cnt_clr) |=> err[c]);
    // R8
    req_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req[c*CNT_W +: CNT_W] == CMAX && !cnt_clr) |=> req[c*CNT_W +: CNT_W] == CMAX);
  end
endmodule

bind lat_accum_monitor lam_chk #(.NCH(NCH), .CNT_W(CNT_W), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
  .iss_q(iss_q), .ret_q(ret_q), .udf_evt(udf_evt), .occ(inflight),
  .err(underflow_err), .req(req_cnt), .cyc(cyc_cnt)
);

// File: tb/lat_accum_monitor_tb.sv
module lat_accum_monitor_tb;
  localparam int NCH = 4, NACC = 4, CW = 8, OW = 8, AW = 2;
  localparam int CMAX = 255, OMAX = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b1, cnt_clr = 1'b0, peer_mode = 1'b0;
  logic [NACC-1:0] acc_mask = '0;
  logic [NCH-1:0] iss_vld = '0, ret_vld = '0;
  logic [NCH*AW-1:0] iss_acc = '0, ret_acc = '0;
  logic [NCH*CW-1:0] req_cnt, cum_cnt;
  logic [CW-1:0] cyc_cnt;
  logic [NCH*OW-1:0] inflight;
  logic [NCH-1:0] underflow_err;

  always #10 clk = ~clk;

  lat_accum_monitor #(.NCH(NCH), .NACC(NACC), .CNT_W(CW), .OCC_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
    .peer_mode(peer_mode), .acc_mask(acc_mask), .iss_vld(iss_vld),
    .iss_acc(iss_acc), .ret_vld(ret_vld), .ret_acc(ret_acc),
    .req_cnt(req_cnt), .cum_cnt(cum_cnt), .cyc_cnt(cyc_cnt),
    .inflight(inflight), .underflow_err(underflow_err)
  );

  typedef struct packed {
    logic [NCH*CW-1:0] req;
    logic [NCH*CW-1:0] cum;
    logic [NCH*OW-1:0] occ;
    logic [CW-1:0]     cyc;
    logic [NCH-1:0]    err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;

  int m_req[NCH], m_cum[NCH], m_occ[NCH], m_cyc;
  logic [NCH-1:0] m_err;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s / %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int capped(int v, int lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic bit picked(logic [AW-1:0] idx);
    return (acc_mask == 0) || acc_mask[idx];
  endfunction

  // Driver: model one edge from the inputs now applied, queue the expectation.
  task automatic step(string tag);
    exp_t e;
    for (int ch = 0; ch < NCH; ch++) begin
      bit live, qi, qr, udf;
      int old;
      live = !(peer_mode && (ch % 2 == 1));
      qi = iss_vld[ch] && live && picked(iss_acc[ch*AW +: AW]);
      qr = ret_vld[ch] && live && picked(ret_acc[ch*AW +: AW]);
      old = m_occ[ch];
      udf = 0;
      if (qi && !qr) m_occ[ch] = capped(old + 1, OMAX);
      else if (qr && !qi) begin
        if (old == 0) udf = 1;
        else m_occ[ch] = old - 1;
      end
      if (cnt_clr) begin
        m_req[ch] = 0; m_cum[ch] = 0; m_err[ch] = 1'b0;
      end else begin
        if (cnt_en) begin
          m_req[ch] = capped(m_req[ch] + int'(qi), CMAX);
          m_cum[ch] = capped(m_cum[ch] + old, CMAX);
        end
        if (udf) m_err[ch] = 1'b1;
      end
    end
    if (cnt_clr) m_cyc = 0;
    else if (cnt_en) m_cyc = capped(m_cyc + 1, CMAX);
    for (int ch = 0; ch < NCH; ch++) begin
      e.req[ch*CW +: CW] = CW'(m_req[ch]);
      e.cum[ch*CW +: CW] = CW'(m_cum[ch]);
      e.occ[ch*OW +: OW] = OW'(m_occ[ch]);
    end
    e.cyc = CW'(m_cyc);
    e.err = m_err;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    iss_vld = '0;
    ret_vld = '0;
  endtask

  // Monitor: compare each queued expectation shortly after its edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "R1 request counters", 64'(req_cnt), 64'(e.req));
        check(t, "R2 cumulative counters", 64'(cum_cnt), 64'(e.cum));
        check(t, "R3 cycle counter", 64'(cyc_cnt), 64'(e.cyc));
        check(t, "R4 in-flight counts", 64'(inflight), 64'(e.occ));
        check(t, "R5 error flags", 64'(underflow_err), 64'(e.err));
      end
    end
  end

  initial begin
    #4_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int ch = 0; ch < NCH; ch++) begin
      m_req[ch] = 0; m_cum[ch] = 0; m_occ[ch] = 0;
    end
    m_cyc = 0;
    m_err = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 reset", "req", 64'(req_cnt), 64'd0);
    check("R11 reset", "cum", 64'(cum_cnt), 64'd0);
    check("R11 reset", "cyc", 64'(cyc_cnt), 64'd0);
    check("R11 reset", "occ", 64'(inflight), 64'd0);
    check("R11 reset", "err", 64'(underflow_err), 64'd0);

    // R1/R2: latency of three edges accumulates 3
    iss_vld = 4'b0001; step("R1 issue ch0");
    step("R2 wait"); step("R2 wait");
    ret_vld = 4'b0001; step("R2 return ch0");
    // R4: simultaneous issue and return
    iss_vld = 4'b0001; step("R4 prime");
    iss_vld = 4'b0001; ret_vld = 4'b0001; step("R4 same edge");
    ret_vld = 4'b0001; step("R4 drain");
    // R5: underflow on channel 2, then stays set
    ret_vld = 4'b0100; step("R5 underflow");
    step("R5 sticky");
    // R6: accelerator mask
    acc_mask = 4'b0010;
    iss_acc = 8'b00_00_00_00; iss_vld = 4'b0001; step("R6 masked out");
    iss_acc = 8'b00_00_00_01; iss_vld = 4'b0001; step("R6 selected");
    ret_acc = 8'b00_00_00_00; ret_vld = 4'b0001; step("R6 masked return");
    ret_acc = 8'b00_00_00_01; ret_vld = 4'b0001; step("R6 selected return");
    acc_mask = '0; iss_acc = '0; ret_acc = '0;
    // R7: peer mode disables write channels
    peer_mode = 1'b1;
    iss_vld = 4'b1111; step("R7 peer issue");
    ret_vld = 4'b1010; step("R7 peer write return ignored");
    ret_vld = 4'b0101; step("R7 peer read return");
    peer_mode = 1'b0;
    // R9: disabled counters hold, occupancy tracks
    cnt_en = 1'b0;
    iss_vld = 4'b0001; step("R9 disabled issue");
    step("R9 disabled idle");
    ret_vld = 4'b0001; step("R9 disabled return");
    cnt_en = 1'b1;
    // R10: clear wins over enable and keeps occupancy
    iss_vld = 4'b0001; step("R10 prime");
    cnt_clr = 1'b1; iss_vld = 4'b0001; step("R10 clear");
    cnt_clr = 1'b0; step("R10 after clear");
    ret_vld = 4'b0001; step("R10 drain"); ret_vld = 4'b0001; step("R10 drain");
    // R8: saturation of every counter and of the occupancy
    for (int i = 0; i < 300; i++) begin
      iss_vld = 4'b1000;
      step("R8 saturation");
    end
    step("R8 hold");
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule